// File: doc/BRIEF.md
# IR carrier burst transmitter

This block drives an infrared emitter pin from a stream of segments. Each segment gives a level (mark or space) and a length counted in whole carrier periods. During a mark the pin carries a pulse-width-modulated carrier. The carrier period is programmed in clock cycles, and a compare value sets where in each period the pin turns on. During a space the pin is held inactive for the whole segment. Software or an upstream engine supplies the segments through a valid/ready handshake. Each segment can carry a packet-end flag and a last flag.

A start pulse given while idle captures the carrier period and the compare value and begins transmission. An inactive lead-in period comes first. Segments longer than the internal repeat counter can hold are cut into full chunks plus a remainder, with no gap between them. When the stream runs dry at a segment boundary, single inactive filler periods keep the carrier timebase running. Transmission ends cleanly in one of two ways: after a segment flagged last, or after the next packet end that follows a stop request. Two inactive periods are then appended, after which busy drops and a done pulse is given.

Top module: `ir_burst_tx`

## Requirements
- R1: After reset, and whenever the block is idle, `ir_out` and `busy` are low; after reset `seg_ready` is high.
- R2: A `start` pulse while idle captures the period (`carrier_period_m1`+1 clocks) and `carrier_cmp`, and raises `busy` on the next cycle. The first carrier period after start is an inactive lead-in period.
- R3: During a mark segment, each carrier period counts a phase from 0 to `carrier_period_m1`. `ir_out` is high when phase >= `carrier_cmp` and low otherwise, so the active part sits at the end of each period.
- R4: During a space segment (`seg_level`=0), `ir_out` stays low for the whole segment.
- R5: A segment with `seg_periods`=n>0 lasts exactly n carrier periods and follows the previous segment with no gap. A segment with n=0 is dropped, together with its flags.
- R6: A segment longer than 2^CNT_W periods is sent as successive chunks of 2^CNT_W periods at the same level, followed by the remainder, with no gap. Its flags act only at the end of the final chunk.
- R7: If no segment is held when a segment ends, one inactive filler period is sent. This repeats until a segment arrives.
- R8: `sent_pulse` is high for one cycle, in the first cycle of the period that follows a segment flagged packet-end or last. It never follows a lead-in, filler or trailing period.
- R9: When a segment flagged last completes, two inactive trailing periods follow. `busy` then falls, and `done_pulse` is high for one cycle in the first idle cycle.
- R10: A `stop_req` while busy takes effect when the next packet-end segment completes, and the packet in progress always finishes. Two trailing periods then follow, then `done_pulse`. A segment still held at termination is discarded.
- R11: While busy, `start` and any change of `carrier_period_m1` or `carrier_cmp` have no effect. A `stop_req` while idle has no effect on the next transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted on this edge when valid |
| seg_level | input | 1 | 1 = mark (carrier), 0 = space |
| seg_periods | input | REQ_W | Segment length in carrier periods |
| seg_pkt_end | input | 1 | Segment closes a packet |
| seg_last | input | 1 | Segment closes the transmission |
| carrier_period_m1 | input | PER_W | Carrier period in clocks, minus one |
| carrier_cmp | input | PER_W | Phase at which the pin turns on within a mark period |
| start | input | 1 | Begin transmission (while idle) |
| stop_req | input | 1 | Stop at the next packet end |
| ir_out | output | 1 | Emitter drive |
| busy | output | 1 | Transmission in progress |
| sent_pulse | output | 1 | A packet-end segment has completed |
| done_pulse | output | 1 | Transmission terminated |

## Verification
The bench builds the block with CNT_W=4, REQ_W=8 and PER_W=8. This makes a chunk 16 periods long, so segments of 16, 17, 20 and 35 periods exercise the split boundary in a few hundred cycles. Short carrier periods of 3 to 5 clocks let each bench cycle be compared against the expected pin value from the requirements. The runs use two duty settings, a stop request in the middle of a packet, an empty stream at start, and inputs changed while busy.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

   // sequencer phase: running user segments, then two trailing periods
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_RUN   = 2'd1,
      PH_TAIL1 = 2'd2,
      PH_TAIL2 = 2'd3
   } ir_phase_e;

endpackage

// File: rtl/ir_seg_slicer.sv
module ir_seg_slicer #(
   parameter int CNT_W = 16,
   parameter int REQ_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             in_level,
   input  logic [REQ_W-1:0] in_periods,
   input  logic             in_pe,
   input  logic             in_last,
   output logic             ck_valid,
   output logic             ck_level,
   output logic [CNT_W-1:0] ck_cnt,
   output logic             ck_pe,
   output logic             ck_last,
   input  logic             ck_take
);

   logic             hold_v, hold_lvl, hold_pe, hold_last;
   logic [REQ_W-1:0] rem;
   logic [REQ_W-1:0] rem_next;
   logic             final_w;

   generate
      if (REQ_W > CNT_W) begin : g_split
         localparam logic [REQ_W-1:0] CHUNK_P = REQ_W'(1) << CNT_W;
         assign final_w  = (rem <= CHUNK_P);
         assign ck_cnt   = final_w ? CNT_W'(rem - REQ_W'(1)) : '1;
         assign rem_next = rem - CHUNK_P;
      end else begin : g_direct
         assign final_w  = 1'b1;
         assign ck_cnt   = CNT_W'(rem - REQ_W'(1));
         assign rem_next = '0;
      end
   endgenerate

   assign in_ready = !hold_v && !flush;
   assign ck_valid = hold_v;
   assign ck_level = hold_lvl;
   assign ck_pe    = hold_pe && final_w;
   assign ck_last  = hold_last && final_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v    <= 1'b0;
         hold_lvl  <= 1'b0;
         hold_pe   <= 1'b0;
         hold_last <= 1'b0;
         rem       <= '0;
      end else if (flush) begin
         hold_v <= 1'b0;
      end else if (hold_v && ck_take) begin
         if (final_w) hold_v <= 1'b0;
         else         rem    <= rem_next;
      end else if (in_valid && in_ready && (in_periods != '0)) begin
         hold_v    <= 1'b1;
         hold_lvl  <= in_level;
         hold_pe   <= in_pe;
         hold_last <= in_last;
         rem       <= in_periods;
      end
   end

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             level,
   input  logic [PER_W-1:0] period_m1,
   input  logic [PER_W-1:0] cmp,
   output logic             wrap,
   output logic             pin
);

   logic [PER_W-1:0] phase;

   assign wrap = run && (phase == period_m1);
   // on-time sits at the tail of each period
   assign pin  = run && level && (phase >= cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              phase <= '0;
      else if (!run || wrap)   phase <= '0;
      else                     phase <= phase + PER_W'(1);
   end

endmodule

// File: rtl/ir_seq_ctrl.sv
module ir_seq_ctrl
   import ir_tx_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop_req,
   input  logic             wrap,
   input  logic             ck_valid,
   input  logic             ck_level,
   input  logic [CNT_W-1:0] ck_cnt,
   input  logic             ck_pe,
   input  logic             ck_last,
   output logic             ck_take,
   output logic             start_ok,
   output logic             run,
   output logic             level,
   output logic             flush,
   output logic             sent,
   output logic             done
);

   ir_phase_e        ph;
   logic [CNT_W-1:0] rep;
   logic             cur_lvl, cur_pe, cur_last, stop_pend;
   logic             seg_end, to_tail, finish, in_run;

   assign run      = (ph != PH_IDLE);
   assign level    = cur_lvl;
   assign in_run   = (ph == PH_RUN);
   assign start_ok = (ph == PH_IDLE) && start;
   assign seg_end  = wrap && (rep == '0);
   assign to_tail  = seg_end && in_run && (cur_last || (cur_pe && (stop_pend || stop_req)));
   assign finish   = seg_end && (ph == PH_TAIL2);
   assign ck_take  = seg_end && in_run && !to_tail && ck_valid;
   assign flush    = finish;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         rep       <= '0;
         cur_lvl   <= 1'b0;
         cur_pe    <= 1'b0;
         cur_last  <= 1'b0;
         stop_pend <= 1'b0;
         sent      <= 1'b0;
         done      <= 1'b0;
      end else begin
         sent <= seg_end && in_run && cur_pe;
         done <= finish;
         if (start_ok) begin
            // lead-in: one inactive period ahead of the first segment
            ph        <= PH_RUN;
            rep       <= '0;
            cur_lvl   <= 1'b0;
            cur_pe    <= 1'b0;
            cur_last  <= 1'b0;
            stop_pend <= 1'b0;
         end else if (run) begin
            if (stop_req) stop_pend <= 1'b1;
            if (wrap && (rep != '0)) rep <= rep - CNT_W'(1);
            if (seg_end) begin
               rep      <= '0;
               cur_lvl  <= 1'b0;
               cur_pe   <= 1'b0;
               cur_last <= 1'b0;
               unique case (ph)
                  PH_RUN: begin
                     if (to_tail) begin
                        ph <= PH_TAIL1;
                     end else if (ck_valid) begin
                        rep      <= ck_cnt;
                        cur_lvl  <= ck_level;
                        cur_pe   <= ck_pe || ck_last;
                        cur_last <= ck_last;
                     end
                  end
                  PH_TAIL1: ph <= PH_TAIL2;
                  PH_TAIL2: begin
                     ph        <= PH_IDLE;
                     stop_pend <= 1'b0;
                  end
                  default: ph <= PH_IDLE;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/ir_burst_tx.sv
module ir_burst_tx #(
   parameter int PER_W = 16,
   parameter int CNT_W = 16,
   parameter int REQ_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seg_valid,
   output logic             seg_ready,
   input  logic             seg_level,
   input  logic [REQ_W-1:0] seg_periods,
   input  logic             seg_pkt_end,
   input  logic             seg_last,
   input  logic [PER_W-1:0] carrier_period_m1,
   input  logic [PER_W-1:0] carrier_cmp,
   input  logic             start,
   input  logic             stop_req,
   output logic             ir_out,
   output logic             busy,
   output logic             sent_pulse,
   output logic             done_pulse
);

   generate
      if (PER_W < 2) begin : g_bad_per
         $error("ir_burst_tx: PER_W must be at least 2");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("ir_burst_tx: CNT_W must be at least 2");
      end
      if (REQ_W < 1) begin : g_bad_req
         $error("ir_burst_tx: REQ_W must be at least 1");
      end
   endgenerate

   logic [PER_W-1:0] per_q, cmp_q;
   logic             ck_valid, ck_level, ck_pe, ck_last, ck_take;
   logic [CNT_W-1:0] ck_cnt;
   logic             flush, start_ok, run, lvl, wrap;

   // carrier settings are captured only when a start is accepted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= '0;
         cmp_q <= '0;
      end else if (start_ok) begin
         per_q <= carrier_period_m1;
         cmp_q <= carrier_cmp;
      end
   end

   ir_seg_slicer #(.CNT_W(CNT_W), .REQ_W(REQ_W)) u_slicer (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(seg_valid), .in_ready(seg_ready), .in_level(seg_level),
      .in_periods(seg_periods), .in_pe(seg_pkt_end), .in_last(seg_last),
      .ck_valid(ck_valid), .ck_level(ck_level), .ck_cnt(ck_cnt),
      .ck_pe(ck_pe), .ck_last(ck_last), .ck_take(ck_take)
   );

   ir_seq_ctrl #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .stop_req(stop_req), .wrap(wrap),
      .ck_valid(ck_valid), .ck_level(ck_level), .ck_cnt(ck_cnt),
      .ck_pe(ck_pe), .ck_last(ck_last), .ck_take(ck_take),
      .start_ok(start_ok), .run(run), .level(lvl), .flush(flush),
      .sent(sent_pulse), .done(done_pulse)
   );

   ir_carrier_gen #(.PER_W(PER_W)) u_carrier (
      .clk(clk), .rst_n(rst_n), .run(run), .level(lvl),
      .period_m1(per_q), .cmp(cmp_q), .wrap(wrap), .pin(ir_out)
   );

   assign busy = run;

endmodule

// File: rtl/ir_burst_tx_chk.sv
module ir_burst_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic ir_out,
   input logic busy,
   input logic sent_pulse,
   input logic done_pulse
);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ir_out);

   // R2
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R9
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_pulse);

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);

   // R8
   sent_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sent_pulse |-> (busy && !done_pulse));

endmodule

bind ir_burst_tx ir_burst_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .ir_out(ir_out),
   .busy(busy), .sent_pulse(sent_pulse), .done_pulse(done_pulse)
);

// File: tb/tb_ir_burst_tx.sv
`timescale 1ns/1ps
module tb_ir_burst_tx;

   localparam int PER_W = 8;
   localparam int CNT_W = 4;
   localparam int REQ_W = 8;
   localparam int CHUNK = 1 << CNT_W;
   localparam int K_LEAD = 0, K_MARK = 1, K_SPACE = 2, K_FILL = 3, K_TAIL = 4;

   typedef struct packed {
      logic       lvl;
      logic [7:0] n;
      logic       pe;
      logic       last;
   } tseg_t;

   // main stream: level, periods, packet end, last
   localparam tseg_t MAIN_T [11] = '{
      '{1'b1, 8'd3,  1'b0, 1'b0},
      '{1'b0, 8'd2,  1'b0, 1'b0},
      '{1'b1, 8'd1,  1'b1, 1'b0},
      '{1'b0, 8'd0,  1'b1, 1'b0},
      '{1'b1, 8'd20, 1'b0, 1'b0},
      '{1'b0, 8'd35, 1'b0, 1'b0},
      '{1'b1, 8'd16, 1'b0, 1'b0},
      '{1'b0, 8'd17, 1'b0, 1'b0},
      '{1'b1, 8'd2,  1'b1, 1'b0},
      '{1'b0, 8'd1,  1'b0, 1'b0},
      '{1'b1, 8'd2,  1'b0, 1'b1}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             seg_valid = 1'b0, seg_level = 1'b0, seg_pkt_end = 1'b0, seg_last = 1'b0;
   logic [REQ_W-1:0] seg_periods = '0;
   logic [PER_W-1:0] carrier_period_m1 = '0, carrier_cmp = '0;
   logic             start = 1'b0, stop_req = 1'b0;
   logic             seg_ready, ir_out, busy, sent_pulse, done_pulse;

   always #10 clk = ~clk;

   ir_burst_tx #(.PER_W(PER_W), .CNT_W(CNT_W), .REQ_W(REQ_W)) dut (
      .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
      .seg_level(seg_level), .seg_periods(seg_periods), .seg_pkt_end(seg_pkt_end),
      .seg_last(seg_last), .carrier_period_m1(carrier_period_m1),
      .carrier_cmp(carrier_cmp), .start(start), .stop_req(stop_req),
      .ir_out(ir_out), .busy(busy), .sent_pulse(sent_pulse), .done_pulse(done_pulse)
   );

   int total_chk = 0, bad_chk = 0;
   bit s_lvl [0:15];
   int s_n   [0:15];
   bit s_pe  [0:15];
   bit s_last[0:15];
   int kind_a[0:511];
   bit sent_a[0:511];
   bit split_a[0:511];
   int np;
   int P, CMP;
   int err_k[0:4];
   int err_split, err_sent, err_busy, end_ok;
   bit mon_done;

   task automatic chk_val(int act, int exp, string what);
      total_chk++;
      if (act != exp) begin
         bad_chk++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic add_p(int kind, bit spl);
      kind_a[np]  = kind;
      split_a[np] = spl;
      np++;
   endtask

   task automatic build_exp(int nseg, int term, int fill);
      for (int i = 0; i < 512; i++) begin
         sent_a[i] = 1'b0; split_a[i] = 1'b0; kind_a[i] = K_TAIL;
      end
      np = 0;
      add_p(K_LEAD, 1'b0);
      for (int i = 0; i < fill; i++) add_p(K_FILL, 1'b0);
      for (int i = 0; i < nseg; i++) begin
         if (s_n[i] == 0) continue;
         for (int k = 0; k < s_n[i]; k++)
            add_p(s_lvl[i] ? K_MARK : K_SPACE, s_n[i] > CHUNK);
         if (s_pe[i] || s_last[i]) sent_a[np] = 1'b1;
         if (i == term) break;
      end
      add_p(K_TAIL, 1'b0);
      add_p(K_TAIL, 1'b0);
   endtask

   task automatic drv(int nseg, int delay);
      repeat (delay) @(negedge clk);
      for (int i = 0; i < nseg; i++) begin
         if (mon_done) break;
         seg_valid   = 1'b1;
         seg_level   = s_lvl[i];
         seg_periods = REQ_W'(s_n[i]);
         seg_pkt_end = s_pe[i];
         seg_last    = s_last[i];
         while (!seg_ready && !mon_done) @(negedge clk);
         if (mon_done) break;
         @(negedge clk);
      end
      seg_valid = 1'b0;
   endtask

   task automatic mon(int stop_c, int meddle_c);
      int last_c;
      last_c = np * P;
      for (int c = 0; c <= last_c; c++) begin
         int pi, ph;
         bit exp_ir, exp_sent;
         pi = c / P;
         ph = c % P;
         if (c == last_c) begin
            end_ok = (busy == 1'b0 && done_pulse == 1'b1) ? 1 : 0;
         end else begin
            exp_ir   = (kind_a[pi] == K_MARK) && (ph >= CMP);
            exp_sent = (ph == 0) && sent_a[pi];
            if (ir_out !== exp_ir) begin
               err_k[kind_a[pi]]++;
               if (split_a[pi]) err_split++;
            end
            if (sent_pulse !== exp_sent) err_sent++;
            if (busy !== 1'b1 || done_pulse !== 1'b0) err_busy++;
         end
         stop_req = (c == stop_c);
         start    = (c == meddle_c);
         if (c == meddle_c) begin
            carrier_period_m1 = 8'd7;
            carrier_cmp       = 8'd0;
         end
         if (c == last_c - 1) mon_done = 1'b1;
         if (c < last_c) @(negedge clk);
      end
      stop_req = 1'b0;
      start    = 1'b0;
   endtask

   task automatic do_run(int per_m1, int cmp, int nseg, int term, int fill,
                         int delay, int stop_c, int meddle_c);
      P   = per_m1 + 1;
      CMP = cmp;
      for (int k = 0; k < 5; k++) err_k[k] = 0;
      err_split = 0; err_sent = 0; err_busy = 0; end_ok = 0;
      mon_done = 1'b0;
      build_exp(nseg, term, fill);
      @(negedge clk);
      carrier_period_m1 = PER_W'(per_m1);
      carrier_cmp       = PER_W'(cmp);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      fork
         drv(nseg, delay);
         mon(stop_c, meddle_c);
      join
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total_chk++;
      bad_chk++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_val(ir_out, 0, "R1 reset ir_out");
      chk_val(busy, 0, "R1 reset busy");
      chk_val(seg_ready, 1, "R1 reset seg_ready");

      // run 1: table walk, split lengths, dropped zero segment, meddling while busy
      for (int i = 0; i < 11; i++) begin
         s_lvl[i]  = MAIN_T[i].lvl;
         s_n[i]    = int'(MAIN_T[i].n);
         s_pe[i]   = MAIN_T[i].pe;
         s_last[i] = MAIN_T[i].last;
      end
      do_run(3, 1, 11, 10, 0, 0, -1, 10);
      chk_val(err_k[K_LEAD], 0, "R2 lead-in period mismatches");
      chk_val(err_k[K_MARK], 0, "R3 mark carrier mismatches (cmp 1 of 4)");
      chk_val(err_k[K_SPACE], 0, "R4 space mismatches");
      chk_val(err_split, 0, "R6 split segment mismatches");
      chk_val(err_sent, 0, "R8 sent_pulse mismatches");
      chk_val(err_k[K_TAIL], 0, "R9 trailing period mismatches");
      chk_val(end_ok, 1, "R5 segment lengths give done at expected cycle");
      chk_val(err_busy, 0, "R11 busy held through start and config changes");
      @(negedge clk);
      chk_val(ir_out, 0, "R1 idle ir_out after run");

      // run 2: stop request in the middle of the first packet
      s_lvl[0] = 1; s_n[0] = 2; s_pe[0] = 0; s_last[0] = 0;
      s_lvl[1] = 0; s_n[1] = 1; s_pe[1] = 1; s_last[1] = 0;
      s_lvl[2] = 1; s_n[2] = 2; s_pe[2] = 0; s_last[2] = 0;
      s_lvl[3] = 0; s_n[3] = 2; s_pe[3] = 1; s_last[3] = 0;
      s_lvl[4] = 1; s_n[4] = 1; s_pe[4] = 0; s_last[4] = 1;
      do_run(4, 3, 5, 1, 0, 0, 7, -1);
      chk_val(err_k[K_MARK], 0, "R3 mark carrier mismatches (cmp 3 of 5)");
      chk_val(err_k[K_TAIL], 0, "R10 trailing periods after stop");
      chk_val(err_sent, 0, "R10 sent_pulse only for finished packet");
      chk_val(end_ok, 1, "R10 done at packet end after stop");
      @(negedge clk);
      chk_val(seg_ready, 1, "R10 held segment discarded at termination");

      // run 3: stop while idle, then empty stream at start
      @(negedge clk);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      s_lvl[0] = 1; s_n[0] = 1; s_pe[0] = 1; s_last[0] = 0;
      s_lvl[1] = 0; s_n[1] = 1; s_pe[1] = 0; s_last[1] = 0;
      s_lvl[2] = 1; s_n[2] = 1; s_pe[2] = 0; s_last[2] = 1;
      do_run(2, 2, 3, 2, 2, 6, -1, -1);
      chk_val(err_k[K_FILL], 0, "R7 filler periods while stream empty");
      chk_val(err_k[K_MARK], 0, "R3 mark carrier mismatches (cmp 2 of 3)");
      chk_val(err_sent, 0, "R8 sent_pulse after each packet end");
      chk_val(end_ok, 1, "R11 idle stop ignored, run ends at last segment");

      $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
   end

endmodule